// File: doc/BRIEF.md
# Pseudo-Random TLB Victim Index Generator

This block picks which translation buffer entry to overwrite when a new mapping has to be installed and software has not named a slot. It keeps a 32-bit Galois shift register and steps it whenever a fresh index is needed. The register state is reduced modulo the number of replaceable slots and offset past the locked region at the bottom of the buffer. The locked region is the first `wiredCount` entries, and those are never returned.

The block never hands out the same index twice in a row. If a reduced value matches the index delivered last time, the shift register is stepped again and the reduction is redone until a different index appears. The reduction is a bit-serial restoring division, so a single attempt takes many cycles and a request can take an unknown number of attempts. For this reason the requester sees a ready/valid handshake. A request is taken only while the block is idle. If the replaceable range holds fewer than two slots, no non-repeating choice exists. In that case the block returns the wired boundary at once and raises an error flag.

Top module: `victim_index_gen`

## Requirements
- R1: After reset, reqReady is 1, idxValid is 0, idxOut is 0 and rangeError is 0. The shift register holds the seed value 1.
- R2: Each attempt advances the shift register exactly once. The state is shifted right by one bit, and when the bit shifted out is 1 the result is XORed with 0xD0000001. The first request after reset with numEntries=16 and wiredCount=0 returns index 1.
- R3: A candidate index equals (shift register state mod (numEntries − wiredCount)) + wiredCount. Every delivered index lies in [wiredCount, numEntries).
- R4: A candidate equal to the previously delivered index is discarded and a new attempt starts. Two consecutive delivered indices always differ.
- R5: idxOut shows the most recently delivered index. It changes only in the cycle in which idxValid is 1.
- R6: idxValid is a one-cycle pulse. It appears 34×k clock edges after the accepting edge, where k is the number of attempts: one step edge, 32 division edges and one compare edge per attempt.
- R7: reqReady is 1 only while idle. A reqValid seen while busy is ignored and starts no second request.
- R8: If numEntries − wiredCount ≤ 1 (including numEntries < wiredCount), the request completes at the edge after acceptance. idxOut becomes wiredCount, rangeError becomes 1, and the shift register does not step. rangeError keeps its value until the next delivery, and a normal delivery clears it.
- R9: numEntries and wiredCount are captured at acceptance. Changes to them while busy do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request for a new victim index |
| reqReady | output | 1 | Block is idle and accepts a request |
| numEntries | input | 6 | Total number of buffer entries |
| wiredCount | input | 6 | Number of locked entries at the bottom |
| idxValid | output | 1 | One-cycle pulse: idxOut carries a new index |
| idxOut | output | 6 | Last delivered index |
| rangeError | output | 1 | Last delivery came from a range too small to choose from |

## Verification
The bench builds the block with its default parameters: 6-bit indices, a 32-bit shift register with tap mask 0xD0000001 and seed 1. With these values the exact reference sequence and the full 34-cycle attempt length are checked. Narrow ranges such as two replaceable slots make repeat rejections frequent, so multi-attempt latencies and back-to-back re-steps are exercised. Ranges of 0 or 1 slot, and the case where the wired count is larger than the entry count, reach the error path. Inputs are changed while the block is busy to show that the captured operands are the ones used.

// File: rtl/vig_pkg.sv
package vig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_DIV,
    ST_CHECK
  } vig_state_t;

  typedef struct packed {
    logic accept;
    logic step;
    logic divStep;
    logic deliver;
    logic deliverErr;
  } vig_strobe_t;

endpackage

// File: rtl/vig_dp.sv
module vig_dp
  import vig_pkg::*;
#(
  parameter int          IDX_W  = 6,
  parameter int          LFSR_W = 32,
  parameter logic [31:0] TAP    = 32'hD000_0001,
  parameter logic [31:0] SEED   = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vig_strobe_t      strb,
  input  logic [IDX_W-1:0] numEntries,
  input  logic [IDX_W-1:0] wiredCount,
  output logic             rangeBad,
  output logic             sameAsPrev,
  output logic [IDX_W-1:0] idxOut,
  output logic             rangeError
);

  localparam int EXT_W = IDX_W + 1;
  localparam logic [LFSR_W-1:0] TAP_V  = LFSR_W'(TAP);
  localparam logic [LFSR_W-1:0] SEED_V = LFSR_W'(SEED);

  logic [LFSR_W-1:0] lfsrState, lfsrNext, dividend;
  logic [IDX_W-1:0]  remReg, remNext, entriesLat, wiredLat, divisor;
  logic [IDX_W-1:0]  candidate, prevIdx;
  logic [EXT_W-1:0]  trial, trialDiff;
  logic              trialFits, errReg;

  // Range check on the live inputs: a span of 0 or 1 (or negative) is unusable
  assign rangeBad = {1'b0, numEntries} <= ({1'b0, wiredCount} + EXT_W'(1));

  assign lfsrNext = (lfsrState >> 1) ^ (lfsrState[0] ? TAP_V : '0);

  // Restoring division, one dividend bit per cycle, MSB first
  assign divisor   = entriesLat - wiredLat;
  assign trial     = {remReg, dividend[LFSR_W-1]};
  assign trialFits = trial >= {1'b0, divisor};
  assign trialDiff = trial - {1'b0, divisor};
  assign remNext   = trialFits ? trialDiff[IDX_W-1:0] : trial[IDX_W-1:0];

  assign candidate  = remReg + wiredLat;
  assign sameAsPrev = (candidate == prevIdx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsrState  <= SEED_V;
      dividend   <= '0;
      remReg     <= '0;
      entriesLat <= '0;
      wiredLat   <= '0;
      prevIdx    <= '0;
      errReg     <= 1'b0;
    end else begin
      if (strb.accept) begin
        entriesLat <= numEntries;
        wiredLat   <= wiredCount;
      end
      if (strb.step) begin
        lfsrState <= lfsrNext;
        dividend  <= lfsrNext;
        remReg    <= '0;
      end else if (strb.divStep) begin
        dividend <= dividend << 1;
        remReg   <= remNext;
      end
      if (strb.deliverErr) begin
        prevIdx <= wiredCount;
        errReg  <= 1'b1;
      end else if (strb.deliver) begin
        prevIdx <= candidate;
        errReg  <= 1'b0;
      end
    end
  end

  assign idxOut     = prevIdx;
  assign rangeError = errReg;

  p_lfsr_alive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsrState != '0);

  p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.deliver |-> (candidate >= wiredLat) && (candidate < entriesLat));

  p_fresh_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.deliver |-> candidate != prevIdx);

  p_hold_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.deliver || strb.deliverErr) |=> $stable(prevIdx));

  p_err_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.deliverErr |=> $stable(lfsrState));

endmodule

// File: rtl/vig_ctrl.sv
module vig_ctrl
  import vig_pkg::*;
#(
  parameter int LFSR_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        rangeBad,
  input  logic        sameAsPrev,
  output vig_strobe_t strb,
  output logic        reqReady,
  output logic        idxValid
);

  localparam int CNT_W = $clog2(LFSR_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(LFSR_W - 1);

  vig_state_t state, stateNext;
  logic [CNT_W-1:0] divCnt;
  logic validReg;

  always_comb begin
    strb            = '0;
    strb.accept     = (state == ST_IDLE) && reqValid;
    strb.deliverErr = strb.accept && rangeBad;
    strb.step       = (state == ST_STEP);
    strb.divStep    = (state == ST_DIV);
    strb.deliver    = (state == ST_CHECK) && !sameAsPrev;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strb.accept && !rangeBad) stateNext = ST_STEP;
      ST_STEP:  stateNext = ST_DIV;
      ST_DIV:   if (divCnt == LAST_BIT) stateNext = ST_CHECK;
      ST_CHECK: stateNext = sameAsPrev ? ST_STEP : ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      validReg <= 1'b0;
    end else begin
      state    <= stateNext;
      validReg <= strb.deliver || strb.deliverErr;
      if (state == ST_DIV) divCnt <= divCnt + CNT_W'(1);
      else                 divCnt <= '0;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign idxValid = validReg;

  p_valid_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idxValid |-> reqReady);

  p_check_after_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK) |-> $past(state == ST_DIV && divCnt == LAST_BIT));

  p_div_after_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP) |=> (state == ST_DIV) && (divCnt == '0));

endmodule

// File: rtl/victim_index_gen.sv
module victim_index_gen
  import vig_pkg::*;
#(
  parameter int          IDX_W  = 6,
  parameter int          LFSR_W = 32,
  parameter logic [31:0] TAP    = 32'hD000_0001,
  parameter logic [31:0] SEED   = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [IDX_W-1:0] numEntries,
  input  logic [IDX_W-1:0] wiredCount,
  output logic             idxValid,
  output logic [IDX_W-1:0] idxOut,
  output logic             rangeError
);

  vig_strobe_t strb;
  logic rangeBad, sameAsPrev;

  vig_ctrl #(.LFSR_W(LFSR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .rangeBad   (rangeBad),
    .sameAsPrev (sameAsPrev),
    .strb       (strb),
    .reqReady   (reqReady),
    .idxValid   (idxValid)
  );

  vig_dp #(.IDX_W(IDX_W), .LFSR_W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .numEntries (numEntries),
    .wiredCount (wiredCount),
    .rangeBad   (rangeBad),
    .sameAsPrev (sameAsPrev),
    .idxOut     (idxOut),
    .rangeError (rangeError)
  );

endmodule

// File: tb/victim_index_gen_bench.sv
module victim_index_gen_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [5:0] numEntries = '0;
  logic [5:0] wiredCount = '0;
  logic reqReady, idxValid, rangeError;
  logic [5:0] idxOut;

  int compared = 0;
  int mismatched = 0;
  bit cmpOn = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  victim_index_gen u_victim_index_gen (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .numEntries(numEntries), .wiredCount(wiredCount),
    .idxValid(idxValid), .idxOut(idxOut), .rangeError(rangeError)
  );

  // Behavioural reference model
  logic [31:0] mLfsr = 32'h1;
  int  mPrev = 0, mPending = 0, mCountdown = 0;
  bit  mBusy = 0, mValid = 0, mErr = 0;

  function automatic logic [31:0] stepOnce(logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'hD000_0001 : 32'h0);
  endfunction

  always @(posedge clk) begin
    mValid = 0;
    if (!rst_n) begin
      mLfsr = 32'h1; mPrev = 0; mBusy = 0; mErr = 0; mCountdown = 0;
    end else if (mBusy) begin
      mCountdown--;
      if (mCountdown == 0) begin
        mBusy = 0; mValid = 1; mPrev = mPending; mErr = 0;
      end
    end else if (reqValid) begin
      int e, w, n, cand;
      e = int'(numEntries); w = int'(wiredCount);
      if (e - w <= 1) begin
        mValid = 1; mPrev = w; mErr = 1;
      end else begin
        n = 0;
        do begin
          mLfsr = stepOnce(mLfsr);
          cand = int'(mLfsr % 32'(e - w)) + w;
          n++;
        end while (cand == mPrev);
        mPending = cand; mCountdown = 34 * n; mBusy = 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      check(reqReady == !mBusy, "R7", "reqReady", int'(reqReady), int'(!mBusy));
      check(idxValid == mValid, "R6", "idxValid", int'(idxValid), int'(mValid));
      check(int'(idxOut) == mPrev, "R5", "idxOut", int'(idxOut), mPrev);
      check(rangeError == mErr, "R8", "rangeError", int'(rangeError), int'(mErr));
    end
  end

  int lastIdx = 0;
  int lastLat = 0;

  // Issue one request while idle; optionally disturb inputs while busy (R7, R9)
  task automatic request(int e, int w, bit disturb);
    @(negedge clk);
    numEntries = 6'(e); wiredCount = 6'(w); reqValid = 1'b1;
    lastLat = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      lastLat++;
      if (disturb && lastLat < 12) begin
        reqValid = 1'b1; numEntries = 6'(lastLat); wiredCount = 6'(63 - lastLat);
      end else begin
        reqValid = 1'b0; numEntries = 6'(e); wiredCount = 6'(w);
      end
      if (idxValid) break;
    end
    reqValid = 1'b0; numEntries = 6'(e); wiredCount = 6'(w);
    check(idxValid == 1'b1, "R6", "delivery seen", int'(idxValid), 1);
    if (e - w > 1) begin
      check(int'(idxOut) >= w && int'(idxOut) < e, "R3", "index in range", int'(idxOut), w);
      check(int'(idxOut) != lastIdx, "R4", "differs from previous", int'(idxOut), lastIdx);
      check(rangeError == 1'b0, "R8", "no error on wide range", int'(rangeError), 0);
      check(lastLat % 34 == 1, "R6", "latency multiple of 34 plus sample", lastLat, 35);
    end else begin
      check(int'(idxOut) == w, "R8", "error returns wired", int'(idxOut), w);
      check(rangeError == 1'b1, "R8", "error flag", int'(rangeError), 1);
      check(lastLat == 1, "R8", "error latency", lastLat, 1);
    end
    lastIdx = int'(idxOut);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(idxValid == 1'b0, "R1", "idxValid after reset", int'(idxValid), 0);
    check(idxOut == 6'd0, "R1", "idxOut after reset", int'(idxOut), 0);
    check(rangeError == 1'b0, "R1", "rangeError after reset", int'(rangeError), 0);

    // R2 first value from seed 1: 0xD0000001 mod 16 = 1
    request(16, 0, 0);
    check(int'(idxOut) == 1, "R2", "first index from seed", int'(idxOut), 1);
    check(lastLat == 35, "R6", "single-attempt latency", lastLat, 35);

    for (int k = 0; k < 6; k++) request(16, 0, 0);
    for (int k = 0; k < 8; k++) request(8, 4, 0);
    for (int k = 0; k < 12; k++) request(6, 4, 0);   // two slots: frequent repeats (R4)
    request(63, 0, 0);
    request(63, 61, 0);

    // R8 error cases, then recovery
    request(5, 4, 0);
    request(3, 10, 0);
    request(0, 0, 0);
    request(20, 3, 0);
    check(rangeError == 1'b0, "R8", "flag cleared by normal delivery", int'(rangeError), 0);

    // R7 / R9 disturbed inputs while busy
    for (int k = 0; k < 4; k++) request(12, 2, 1);
    request(40, 30, 1);

    // R5 idle cycles leave idxOut alone
    repeat (20) @(negedge clk);
    check(int'(idxOut) == lastIdx, "R5", "idxOut stable while idle", int'(idxOut), lastIdx);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule